// File: doc/BRIEF.md
# Masked Byte-Lane Write Unit

This unit turns the strobes of a page-mode memory cycle into one write-enable bit per stored bit. The stored word is four 8-bit data lanes, and each lane has one parity bit stacked above it, so the word is 36 bits wide. Each data lane has its own active-low column strobe. The four parity bits share a fifth active-low strobe. A lane or a parity bit is written only while the shared active-low write enable is also low, so each column strobe works as a byte-write select.

Parity bits can also be masked one bit at a time. When the row strobe falls to open a write cycle, the unit samples the parity positions of the data pins (bits 8, 17, 26 and 35) as a mask. A 1 in the mask lets that parity bit be written and a 0 blocks it. The mask stays fixed for every write of the page burst and is cleared when the row strobe rises. A build option removes the parity bits and the mask logic, which gives a plain 32-bit word. All strobes are sampled on the system clock. The per-bit enables and the matching data word are registered, so each appears one clock after the strobe sample that caused it.

A small state machine tracks the row cycle. ROW_IDLE waits with the row strobe high. On a qualified fall it goes to ROW_WRITE: the write mode is high and every column strobe and the write enable are high. Any other fall goes to ROW_BLOCKED, which covers a read cycle or a cycle started with a column strobe or the write enable already low. ROW_WRITE and ROW_BLOCKED both go back to ROW_IDLE when the row strobe is sampled high. The state is ROW_IDLE after reset. If the row strobe is low when reset is released, that first sample counts as a fall.

Top module: `bwu_write_unit`

## Requirements
- R1: After reset, bit_we and wr_data are all zero, and no write happens until a qualified row-strobe fall.
- R2: A fall of row_n that is sampled while any column strobe or wen_n is low gives a blocked cycle. No bit is written until row_n has been sampled high again.
- R3: In an open write cycle, with row_n low, lane i's column strobe low and wen_n low in the same sample, the 8 data bits of lane i are enabled one clock later. Lane i occupies bits 9*i to 9*i+7 of the 36-bit word.
- R4: With wen_n high nothing is written. A lane whose column strobe is high is not written.
- R5: The parity mask is taken from dq_in bits 8, 17, 26 and 35 (parity of lanes 0 to 3) when the write cycle opens. Parity bit i is written only when par_col_n is low, wen_n is low and mask bit i is 1.
- R6: The mask does not change during a burst, whatever appears on the parity pins later in the cycle.
- R7: A sample with row_n high ends the cycle. That sample writes nothing and the mask is cleared. The next write cycle uses the mask sampled at its own fall.
- R8: A row cycle opened with wr_mode low (read) writes nothing, whatever the strobes do.
- R9: wr_data holds the dq_in sample taken at the same clock as the strobes that produced the current bit_we.
- R10: par_col_n enables only parity bits and the lane strobes enable only data bits.
- R11: With PARITY_EN=0 the word is 32 bits and lane i occupies bits 8*i to 8*i+7. There is no parity strobe and no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | input | 1 | Row strobe, active low; a fall starts a row cycle |
| wr_mode | input | 1 | Sampled at the row fall: 1 write cycle, 0 read cycle |
| lane_col_n | input | LANES (4) | Per-lane column strobes, active low |
| par_col_n | input | 1 | Column strobe shared by the parity bits, active low |
| wen_n | input | 1 | Shared write enable, active low |
| dq_in | input | WORD (36) | Data pins; the parity positions carry the mask at the row fall |
| bit_we | output | WORD (36) | Registered per-bit write enables |
| wr_data | output | WORD (36) | Registered data word aligned with bit_we |

## Verification
The bench covers five failure modes, each of which a plausible mistake would produce:
- **Mask refresh:** it changes the parity pins in the middle of a burst. A design that re-sampled the mask there would write parity bits that were masked off.
- **Stale mask:** it opens a second write cycle with a different mask. A design that never cleared or reloaded the mask would reuse the old parity selection.
- **Illegal or read starts:** it opens a cycle with a column strobe already low, and another as a read. A design that qualified only on write mode, or that decided per access, would write in cycles that must stay dead.
- **Strobe crossover:** it drives the parity strobe alone and the lane strobes alone. A wiring slip between data and parity enables would show at once.
- **Release sample:** it holds the strobes low in the same sample as the row release, which catches a design that writes on the closing edge.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

    // Row-cycle state of the write unit
    typedef enum logic [1:0] {
        ROW_IDLE    = 2'd0,   // row strobe high, waiting for a fall
        ROW_WRITE   = 2'd1,   // qualified write cycle open
        ROW_BLOCKED = 2'd2    // read or illegally started cycle, no writes
    } row_state_e;

endpackage

// File: rtl/bwu_row_fsm.sv
module bwu_row_fsm
    import bwu_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int PARITY_EN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_n,
    input  logic             wr_mode,
    input  logic [LANES-1:0] lane_col_n,
    input  logic             par_col_n,
    input  logic             wen_n,
    output row_state_e       state,
    output logic             capture,
    output logic             open_write,
    output logic             release_o
);

    row_state_e state_q, state_d;
    logic       strobes_idle;
    logic       par_idle;

    // The parity strobe only takes part when parity exists
    generate
        if (PARITY_EN != 0) begin : g_par
            assign par_idle = par_col_n;
        end else begin : g_nopar
            assign par_idle = 1'b1;
        end
    endgenerate

    assign strobes_idle = (&lane_col_n) & par_idle & wen_n;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROW_IDLE: begin
                if (!row_n) begin
                    if (wr_mode && strobes_idle)
                        state_d = ROW_WRITE;
                    else
                        state_d = ROW_BLOCKED;
                end
            end
            ROW_WRITE: begin
                if (row_n)
                    state_d = ROW_IDLE;
            end
            ROW_BLOCKED: begin
                if (row_n)
                    state_d = ROW_IDLE;
            end
            default: state_d = ROW_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ROW_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs decoded from the present state and the row strobe
    always_comb begin
        capture    = 1'b0;
        open_write = 1'b0;
        release_o  = 1'b0;
        unique case (state_q)
            ROW_IDLE: begin
                capture   = !row_n;
                release_o = row_n;
            end
            ROW_WRITE: begin
                open_write = !row_n;
                release_o  = row_n;
            end
            ROW_BLOCKED: begin
                release_o = row_n;
            end
            default: release_o = row_n;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bwu_mask_hold.sv
module bwu_mask_hold #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             release_i,
    input  logic [LANES-1:0] par_pins,
    output logic [LANES-1:0] mask
);

    logic [LANES-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (release_i)
            mask_q <= '0;
        else if (capture)
            mask_q <= par_pins;
    end

    assign mask = mask_q;

endmodule

// File: rtl/bwu_lane_gate.sv
module bwu_lane_gate #(
    parameter int LANE_BITS = 8,
    parameter int HAS_PAR   = 1
) (
    input  logic                 open_write,
    input  logic                 wen_n,
    input  logic                 col_n,
    input  logic                 par_col_n,
    input  logic                 mask_bit,
    output logic [LANE_BITS-1:0] data_we,
    output logic                 par_we
);

    logic write_slot;

    assign write_slot = open_write & ~wen_n;
    assign data_we    = {LANE_BITS{write_slot & ~col_n}};

    generate
        if (HAS_PAR != 0) begin : g_par
            assign par_we = write_slot & ~par_col_n & mask_bit;
        end else begin : g_nopar
            assign par_we = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bwu_write_unit.sv
module bwu_write_unit
    import bwu_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8,
    parameter int PARITY_EN = 1,
    localparam int SLICE    = LANE_BITS + ((PARITY_EN != 0) ? 1 : 0),
    localparam int WORD     = LANES * SLICE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_n,
    input  logic             wr_mode,
    input  logic [LANES-1:0] lane_col_n,
    input  logic             par_col_n,
    input  logic             wen_n,
    input  logic [WORD-1:0]  dq_in,
    output logic [WORD-1:0]  bit_we,
    output logic [WORD-1:0]  wr_data
);

    row_state_e       state;
    logic             capture;
    logic             open_write;
    logic             release_w;
    logic [LANES-1:0] mask;
    logic [LANES-1:0] par_we;
    logic [WORD-1:0]  we_next;

    bwu_row_fsm #(
        .LANES     (LANES),
        .PARITY_EN (PARITY_EN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_n      (row_n),
        .wr_mode    (wr_mode),
        .lane_col_n (lane_col_n),
        .par_col_n  (par_col_n),
        .wen_n      (wen_n),
        .state      (state),
        .capture    (capture),
        .open_write (open_write),
        .release_o  (release_w)
    );

    generate
        if (PARITY_EN != 0) begin : g_mask
            logic [LANES-1:0] par_pins;
            for (genvar p = 0; p < LANES; p++) begin : g_pin
                assign par_pins[p] = dq_in[p*SLICE + LANE_BITS];
            end
            bwu_mask_hold #(
                .LANES (LANES)
            ) u_mask (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture   (capture),
                .release_i (release_w),
                .par_pins  (par_pins),
                .mask      (mask)
            );
        end else begin : g_nomask
            assign mask = '0;
        end
    endgenerate

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            bwu_lane_gate #(
                .LANE_BITS (LANE_BITS),
                .HAS_PAR   (PARITY_EN)
            ) u_gate (
                .open_write (open_write),
                .wen_n      (wen_n),
                .col_n      (lane_col_n[i]),
                .par_col_n  (par_col_n),
                .mask_bit   (mask[i]),
                .data_we    (we_next[i*SLICE +: LANE_BITS]),
                .par_we     (par_we[i])
            );
            if (PARITY_EN != 0) begin : g_pbit
                assign we_next[i*SLICE + LANE_BITS] = par_we[i];
            end
        end
    endgenerate

    // Enables and data leave together, one clock after the strobe sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_we  <= '0;
            wr_data <= '0;
        end else begin
            bit_we  <= we_next;
            wr_data <= dq_in;
        end
    end

endmodule

// File: rtl/bwu_checker.sv
module bwu_checker
    import bwu_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8,
    parameter int PARITY_EN = 1,
    localparam int SLICE    = LANE_BITS + ((PARITY_EN != 0) ? 1 : 0),
    localparam int WORD     = LANES * SLICE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_n,
    input logic             wen_n,
    input logic [LANES-1:0] lane_col_n,
    input logic             par_col_n,
    input row_state_e       state,
    input logic [LANES-1:0] mask,
    input logic [WORD-1:0]  bit_we
);

    // R7: a sample with the row strobe high writes nothing
    a_r7_release_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        row_n |=> (bit_we == '0));

    // R4: write enable high blocks every bit
    a_r4_wen_high_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wen_n |=> (bit_we == '0));

    // R2 / R8: a blocked cycle never writes
    a_r8_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ROW_BLOCKED) |=> (bit_we == '0));

    // R6: the mask is stable across an open burst
    a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ROW_WRITE && !row_n) |=> $stable(mask));

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_chk
            // R3: qualified lane strobe writes the full lane
            a_r3_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ROW_WRITE && !row_n && !wen_n && !lane_col_n[i])
                |=> (&bit_we[i*SLICE +: LANE_BITS]));
            // R4: an idle lane strobe leaves the lane alone
            a_r4_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
                lane_col_n[i] |=> (bit_we[i*SLICE +: LANE_BITS] == '0));
            if (PARITY_EN != 0) begin : g_pchk
                // R5: parity bit needs its strobe and its mask bit
                a_r5_parity_gate: assert property (@(posedge clk) disable iff (!rst_n)
                    (par_col_n || !mask[i]) |=> !bit_we[i*SLICE + LANE_BITS]);
            end
        end
    endgenerate

endmodule

bind bwu_write_unit bwu_checker #(
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS),
    .PARITY_EN (PARITY_EN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_n      (row_n),
    .wen_n      (wen_n),
    .lane_col_n (lane_col_n),
    .par_col_n  (par_col_n),
    .state      (state),
    .mask       (mask),
    .bit_we     (bit_we)
);

// File: tb/sim_bwu_write_unit.sv
`timescale 1ns/1ps
module sim_bwu_write_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        row_n;
    logic        wr_mode;
    logic [3:0]  lane_col_n;
    logic        par_col_n;
    logic        wen_n;
    logic [35:0] dq_in;
    logic [35:0] bit_we;
    logic [35:0] wr_data;
    logic [31:0] dq_in32;
    logic [31:0] bit_we32;
    logic [31:0] wr_data32;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bwu_write_unit u0 (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .wr_mode(wr_mode),
        .lane_col_n(lane_col_n), .par_col_n(par_col_n), .wen_n(wen_n),
        .dq_in(dq_in), .bit_we(bit_we), .wr_data(wr_data)
    );

    bwu_write_unit #(.PARITY_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .wr_mode(wr_mode),
        .lane_col_n(lane_col_n), .par_col_n(par_col_n), .wen_n(wen_n),
        .dq_in(dq_in32), .bit_we(bit_we32), .wr_data(wr_data32)
    );

    // Vector: {row_n, wr_mode, lane_col_n[3:0], par_col_n, wen_n, dq[35:0], expected bit_we[35:0]}
    localparam int NV = 18;
    localparam logic [79:0] VEC [NV] = '{
        {1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},          // idle
        {1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 36'h004000100, 36'h0},          // R5 open, mask lanes 0,2
        {1'b0, 1'b1, 4'hE, 1'b1, 1'b0, 36'h0,         36'h0000000FF},  // R3 lane0
        {1'b0, 1'b1, 4'h5, 1'b1, 1'b1, 36'h0,         36'h0},          // R4 wen high
        {1'b0, 1'b1, 4'h7, 1'b0, 1'b0, 36'h804020100, 36'h7FC000100},  // R6 lane3 + masked parity
        {1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 36'h0,         36'h004000100},  // R10 parity only
        {1'b1, 1'b1, 4'hE, 1'b1, 1'b0, 36'h0,         36'h0},          // R7 release sample
        {1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 36'h800020000, 36'h0},          // R7 new mask lanes 1,3
        {1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 36'h0,         36'h800020000},  // R7 new mask used
        {1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},
        {1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},          // R8 read open
        {1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 36'hFFFFFFFFF, 36'h0},          // R8 no write
        {1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},
        {1'b0, 1'b1, 4'hB, 1'b1, 1'b1, 36'h0,         36'h0},          // R2 illegal open
        {1'b0, 1'b1, 4'hB, 1'b1, 1'b0, 36'h0,         36'h0},          // R2 blocked
        {1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},
        {1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0,         36'h0},          // open, empty mask
        {1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 36'h0,         36'h7FBFDFEFF}   // R3 R10 all lanes, no parity
    };

    task automatic drive(input logic r, input logic w, input logic [3:0] c,
                         input logic p, input logic we, input logic [35:0] d);
        row_n = r; wr_mode = w; lane_col_n = c; par_col_n = p; wen_n = we; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check36(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        row_n = 1'b1; wr_mode = 1'b1; lane_col_n = 4'hF; par_col_n = 1'b1;
        wen_n = 1'b1; dq_in = '0; dq_in32 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check36("R1 bit_we reset", bit_we, 36'h0);
        check36("R1 wr_data reset", wr_data, 36'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][79], VEC[k][78], VEC[k][77:74], VEC[k][73], VEC[k][72], VEC[k][71:36]);
            check36($sformatf("R3/R4/R5 vector %0d", k), bit_we, VEC[k][35:0]);
        end

        // R9: data aligned with enables
        drive(1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0);
        drive(1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0);
        drive(1'b0, 1'b1, 4'hE, 1'b1, 1'b0, 36'h123456789);
        check36("R9 bit_we", bit_we, 36'h0000000FF);
        check36("R9 wr_data", wr_data, 36'h123456789);

        // R11: 32-bit variant, lane 2 at bits 16..23
        drive(1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0);
        drive(1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 36'h0);
        dq_in32 = 32'hCAFEF00D;
        drive(1'b0, 1'b1, 4'hB, 1'b0, 1'b0, 36'h0);
        check36("R11 bit_we32", {4'h0, bit_we32}, {4'h0, 32'h00FF0000});
        check36("R11 wr_data32", {4'h0, wr_data32}, {4'h0, 32'hCAFEF00D});

        // R1: reset mid-burst, then a fall with strobes low is blocked
        rst_n = 1'b0;
        @(negedge clk);
        check36("R1 bit_we after reset", bit_we, 36'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 36'hFFFFFFFFF);
        drive(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 36'hFFFFFFFFF);
        check36("R1 R2 no write after reset", bit_we, 36'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule